// File: doc/BRIEF.md
# Dual-Timing Multiplexed-Bus Register Port

This block is the slave side of a narrow multiplexed address/data bus that fronts a 128-byte register array. The shared bus carries an address first and then data. An address strobe marks the address phase. A data phase follows, and a single mode pin sets how that phase is read. With the mode pin high, the bus uses a data strobe together with a read/write level. With it low, the bus uses an active-low output enable and an active-low write enable. The tri-state bus is split into an input byte, an output byte and an output-enable bit, so that the pad logic can be built outside the block.

All pins are asynchronous to the block's system clock. Each pin passes through a two-flop synchronizer, and every edge is found on the synchronized copies. An address-valid flag gates every access. The flag is set when an address is captured. It is cleared when the address strobe rises, and also when a data phase runs while the chip is not selected. An access can only take effect after a fresh address capture. A power-fail input deselects the chip internally, so the array cannot be read or written while it is high.

Top module: `mux_bus_port`

## Requirements
- R1: On the falling edge of the address strobe, the low 7 bits of the bus input are captured as the address and the address-valid flag is set. The bus must be held for at least three clocks after that edge.
- R2: A rising edge of the address strobe clears the address-valid flag. Until the next falling edge, no read drives the bus and no write changes the array.
- R3: Chip-select is active low. While it is high, a data phase drives nothing (output enable stays 0) and writes nothing to the array.
- R4: When a data phase runs with chip-select high, the address-valid flag is cleared. A later data phase with chip-select low has no effect until the address strobe has pulsed again.
- R5: Mode pin high, read: while the data strobe is high and read/write is high (1 = read), output enable is 1 and the output byte equals the array entry at the latched address. When the data strobe returns low, output enable returns to 0.
- R6: Mode pin high, write: with read/write low (0 = write), the bus input byte is written to the latched address on the falling edge of the data strobe.
- R7: Mode pin low, write: the read/write pin acts as an active-low write enable. The bus input byte is written on its rising edge.
- R8: Mode pin low, read: the data-strobe pin acts as an active-low output enable. While it is low and the write enable is high, output enable is 1 with the addressed entry on the output byte. Raising it returns output enable to 0.
- R9: While power-fail is high, no read drives the bus and no write reaches the array. Contents written before power-fail are still present after it falls.
- R10: Only the low 7 address bits select the entry, so address 0x85 reaches the same entry as 0x05.
- R11: After reset, output enable is 0 and every array entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 1 = strobe plus read/write level; 0 = separate active-low enables |
| cs_n | input | 1 | Active-low chip select |
| as_strb | input | 1 | Address strobe; address captured on its falling edge |
| ds_pin | input | 1 | Data strobe (mode 1) or active-low output enable (mode 0) |
| rw_pin | input | 1 | Read/write level (mode 1) or active-low write enable (mode 0) |
| pwr_fail | input | 1 | Power-fail; high blocks all accesses |
| bus_in | input | 8 | Multiplexed bus, input side |
| bus_out | output | 8 | Read data, output side |
| bus_oe | output | 1 | High while the block drives read data |

## Verification
A pin change reaches the synchronized level after two rising clock edges. The address capture, the array write and the registered output enable and output byte all update on the third edge. Chip-select and power-fail are qualified over two samples, so their effect arrives one edge after that. The bench changes one pin at a time at a falling clock edge, then waits four full clock periods before it samples or makes the next change. Each result is therefore read at a falling edge, after it has settled and before any later stimulus could reach it. Results of writes and of ignored accesses are confirmed by reading the affected entry back through a normal, fully qualified read cycle.

// File: rtl/mbp_pkg.sv
// Package: shared constants for the multiplexed-bus register port.
// Assumes: the synchronizer bank orders its pins as listed by the index constants.
package mbp_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int NSYNC   = 6;

    localparam int SI_AS   = 0;
    localparam int SI_DS   = 1;
    localparam int SI_RW   = 2;
    localparam int SI_CS   = 3;
    localparam int SI_PF   = 4;
    localparam int SI_MODE = 5;

    // Reset value of every synchronizer chain: idle levels of the pins.
    localparam logic [NSYNC-1:0] SYNC_IDLE = 6'b101100;
endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Two-flop synchronizer bank with one extra history flop per pin, so that
// consumers can detect edges and check stability on synchronized samples.
// Assumes: pins are asynchronous levels; RST_VAL holds each pin's idle level.
module strobe_sync #(
    parameter int               N       = 6,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] lvl_d
);
    for (genvar i = 0; i < N; i++) begin : g_chain
        logic meta_q;
        logic sync_q;
        logic hist_q;

        // Purpose: move one pin into the clock domain and keep one sample of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
                hist_q <= RST_VAL[i];
            end else begin
                meta_q <= pin_in[i];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign lvl[i]   = sync_q;
        assign lvl_d[i] = hist_q;
    end
endmodule

// File: rtl/addr_latch.sv
// Module: addr_latch
// Holds the latched address and its valid flag. A falling address strobe captures
// the bus and sets the flag; a rising strobe clears both; kill clears the flag.
// Assumes: the bus holds the address for three clocks after the strobe falls.
module addr_latch #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_lvl,
    input  logic          as_lvl_d,
    input  logic [AW-1:0] bus_addr,
    input  logic          kill,
    output logic [AW-1:0] addr,
    output logic          addr_valid
);
    logic as_fall;
    logic as_rise;

    // Purpose: find address-strobe edges on the synchronized copy.
    always_comb begin
        as_fall = as_lvl_d & ~as_lvl;
        as_rise = as_lvl & ~as_lvl_d;
    end

    // Purpose: capture, clear and invalidate the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr       <= '0;
            addr_valid <= 1'b0;
        end else if (as_rise) begin
            addr       <= '0;
            addr_valid <= 1'b0;
        end else if (as_fall) begin
            addr       <= bus_addr;
            addr_valid <= 1'b1;
        end else if (kill) begin
            addr_valid <= 1'b0;
        end
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        as_fall |=> (addr_valid && addr == $past(bus_addr)));

    p_clear_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        as_rise |=> !addr_valid);
endmodule

// File: rtl/access_ctrl.sv
// Module: access_ctrl
// Decodes the data phase for either timing mode, qualifies it with chip select,
// power-fail and the address-valid flag, and registers the read output.
// Assumes: inputs are synchronized samples (current and previous).
module access_ctrl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_lvl,
    input  logic          mode_lvl_d,
    input  logic          ds_lvl,
    input  logic          ds_lvl_d,
    input  logic          rw_lvl,
    input  logic          rw_lvl_d,
    input  logic          cs_n_lvl,
    input  logic          cs_n_lvl_d,
    input  logic          pf_lvl,
    input  logic          pf_lvl_d,
    input  logic          addr_valid,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic          kill,
    output logic          oe_q,
    output logic [DW-1:0] dout_q
);
    logic cs_act;
    logic mode_ok;
    logic dphase;
    logic rd_cond;
    logic wr_evt;
    logic rd_go;

    // Purpose: select is live only if held over two samples with no power fail.
    always_comb begin
        cs_act  = ~cs_n_lvl & ~cs_n_lvl_d & ~pf_lvl & ~pf_lvl_d;
        mode_ok = (mode_lvl == mode_lvl_d);
    end

    // Purpose: per-mode decode of data phase, read level and write event.
    always_comb begin
        if (mode_lvl) begin
            dphase  = ds_lvl;
            rd_cond = ds_lvl & rw_lvl;
            wr_evt  = ds_lvl_d & ~ds_lvl & ~rw_lvl;
        end else begin
            dphase  = ~ds_lvl | ~rw_lvl;
            rd_cond = ~ds_lvl & rw_lvl;
            wr_evt  = rw_lvl & ~rw_lvl_d;
        end
    end

    // Purpose: qualify accesses and flag address-only data phases.
    always_comb begin
        wr_en = wr_evt & cs_act & addr_valid & mode_ok;
        rd_go = rd_cond & cs_act & addr_valid & mode_ok;
        kill  = dphase & ~cs_act & addr_valid;
    end

    // Purpose: register the output enable and read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            oe_q   <= rd_go;
            dout_q <= rd_go ? rd_data : '0;
        end
    end

    p_oe_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> $past(!cs_n_lvl && addr_valid));

    p_kill_drops_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> !wr_en);
endmodule

// File: rtl/reg_array.sv
// Module: reg_array
// 2**AW by DW flop array with one write port and an asynchronous read port.
// Assumes: a single write per clock; contents clear on reset.
module reg_array #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: clear on reset, otherwise store the qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Purpose: read the addressed entry.
    assign rd_data = mem[addr];

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/mux_bus_port.sv
// Module: mux_bus_port (top)
// Slave port for a 128-byte array on a multiplexed bus, with two timing modes
// chosen by mode_sel. The tri-state bus is split into in, out and enable.
// Assumes: one pin changes at a time, each held for at least three clocks.
module mux_bus_port
    import mbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              cs_n,
    input  logic              as_strb,
    input  logic              ds_pin,
    input  logic              rw_pin,
    input  logic              pwr_fail,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    logic [NSYNC-1:0]  pins;
    logic [NSYNC-1:0]  s_lvl;
    logic [NSYNC-1:0]  s_lvl_d;
    logic [ADDR_W-1:0] addr;
    logic              addr_valid;
    logic              kill;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    // Purpose: gather the pins in synchronizer order.
    always_comb begin
        pins          = '0;
        pins[SI_AS]   = as_strb;
        pins[SI_DS]   = ds_pin;
        pins[SI_RW]   = rw_pin;
        pins[SI_CS]   = cs_n;
        pins[SI_PF]   = pwr_fail;
        pins[SI_MODE] = mode_sel;
    end

    strobe_sync #(.N(NSYNC), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pins),
        .lvl    (s_lvl),
        .lvl_d  (s_lvl_d)
    );

    addr_latch #(.AW(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_lvl     (s_lvl[SI_AS]),
        .as_lvl_d   (s_lvl_d[SI_AS]),
        .bus_addr   (bus_in[ADDR_W-1:0]),
        .kill       (kill),
        .addr       (addr),
        .addr_valid (addr_valid)
    );

    access_ctrl #(.DW(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_lvl   (s_lvl[SI_MODE]),
        .mode_lvl_d (s_lvl_d[SI_MODE]),
        .ds_lvl     (s_lvl[SI_DS]),
        .ds_lvl_d   (s_lvl_d[SI_DS]),
        .rw_lvl     (s_lvl[SI_RW]),
        .rw_lvl_d   (s_lvl_d[SI_RW]),
        .cs_n_lvl   (s_lvl[SI_CS]),
        .cs_n_lvl_d (s_lvl_d[SI_CS]),
        .pf_lvl     (s_lvl[SI_PF]),
        .pf_lvl_d   (s_lvl_d[SI_PF]),
        .addr_valid (addr_valid),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .kill       (kill),
        .oe_q       (bus_oe),
        .dout_q     (bus_out)
    );

    reg_array #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (bus_in),
        .rd_data (rd_data)
    );

    p_pf_blocks_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !s_lvl[SI_PF]);

    p_oe_low_in_pf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lvl[SI_PF] && s_lvl_d[SI_PF]) |=> !bus_oe);
endmodule

// File: tb/mux_bus_port_test.sv
module mux_bus_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int NV         = 10;

    // Fields: [25] mode, [24] 1=write, [23:16] addr, [15:8] wdata, [7:0] expected read
    localparam logic [25:0] VEC [NV] = '{
        26'h310A500, 26'h21000A5, 26'h1203C00, 26'h020003C, 26'h01000A5,
        26'h220003C, 26'h3855A00, 26'h005005A, 26'h37FFF00, 26'h07F00FF
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b1;
    logic       cs_n = 1'b1;
    logic       as_strb = 1'b0;
    logic       ds_pin = 1'b0;
    logic       rw_pin = 1'b1;
    logic       pwr_fail = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_port uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
        .as_strb(as_strb), .ds_pin(ds_pin), .rw_pin(rw_pin),
        .pwr_fail(pwr_fail), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_mode(input logic m);
        mode_sel = m;
        ds_pin   = ~m;
        rw_pin   = 1'b1;
        settle();
    endtask

    task automatic addr_phase(input logic [7:0] a);
        bus_in  = a;
        as_strb = 1'b1;
        settle();
        as_strb = 1'b0;
        settle();
    endtask

    task automatic moto_wr(input logic [7:0] d, input logic sel);
        cs_n   = ~sel;
        rw_pin = 1'b0;
        bus_in = d;
        settle();
        ds_pin = 1'b1;
        settle();
        ds_pin = 1'b0;
        settle();
        rw_pin = 1'b1;
        cs_n   = 1'b1;
        settle();
    endtask

    task automatic moto_rd(input logic sel, output logic oe_on, output logic [7:0] dat,
                           output logic oe_off);
        cs_n   = ~sel;
        rw_pin = 1'b1;
        settle();
        ds_pin = 1'b1;
        settle();
        oe_on  = bus_oe;
        dat    = bus_out;
        ds_pin = 1'b0;
        settle();
        oe_off = bus_oe;
        cs_n   = 1'b1;
        settle();
    endtask

    task automatic intel_wr(input logic [7:0] d, input logic sel);
        cs_n   = ~sel;
        bus_in = d;
        settle();
        rw_pin = 1'b0;
        settle();
        rw_pin = 1'b1;
        settle();
        cs_n   = 1'b1;
        settle();
    endtask

    task automatic intel_rd(input logic sel, output logic oe_on, output logic [7:0] dat,
                            output logic oe_off);
        cs_n = ~sel;
        settle();
        ds_pin = 1'b0;
        settle();
        oe_on  = bus_oe;
        dat    = bus_out;
        ds_pin = 1'b1;
        settle();
        oe_off = bus_oe;
        cs_n   = 1'b1;
        settle();
    endtask

    task automatic do_read(input logic [7:0] a, output logic oe_on, output logic [7:0] dat,
                           output logic oe_off);
        addr_phase(a);
        if (mode_sel) moto_rd(1'b1, oe_on, dat, oe_off);
        else          intel_rd(1'b1, oe_on, dat, oe_off);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic       on;
        logic       off;
        logic [7:0] dat;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R11: reset state
        check("R11 oe after reset", {7'd0, bus_oe}, 8'h00);
        do_read(8'h33, on, dat, off);
        check("R11 entry 0x33 after reset", dat, 8'h00);
        check("R5 oe during read", {7'd0, on}, 8'h01);
        check("R5 oe released after strobe", {7'd0, off}, 8'h00);

        // Vector table: R6/R7 writes, R5/R8 reads, R10 aliasing
        for (int i = 0; i < NV; i++) begin
            logic       m;
            logic       w;
            logic [7:0] a;
            logic [7:0] d;
            logic [7:0] e;
            {m, w, a, d, e} = VEC[i];
            if (mode_sel != m) set_mode(m);
            if (w) begin
                addr_phase(a);
                if (m) moto_wr(d, 1'b1);
                else   intel_wr(d, 1'b1);
            end else begin
                do_read(a, on, dat, off);
                check(m ? "R5/R6 vector read data" : "R7/R8/R10 vector read data", dat, e);
                check(m ? "R5 vector oe" : "R8 vector oe", {7'd0, on}, 8'h01);
                check(m ? "R5 vector release" : "R8 vector release", {7'd0, off}, 8'h00);
            end
        end

        // R3: chip-select high, mode 1
        set_mode(1'b1);
        addr_phase(8'h10);
        moto_wr(8'h00, 1'b0);
        addr_phase(8'h10);
        moto_rd(1'b0, on, dat, off);
        check("R3 oe with cs high", {7'd0, on}, 8'h00);
        do_read(8'h10, on, dat, off);
        check("R3 no write with cs high", dat, 8'hA5);

        // R2: rising address strobe clears the address
        addr_phase(8'h20);
        as_strb = 1'b1;
        settle();
        moto_rd(1'b1, on, dat, off);
        check("R2 oe after strobe rise", {7'd0, on}, 8'h00);
        moto_wr(8'h99, 1'b1);
        do_read(8'h20, on, dat, off);
        check("R2 no write after strobe rise", dat, 8'h3C);

        // R4: address-only cycle then select without fresh strobe
        addr_phase(8'h7F);
        ds_pin = 1'b1;
        settle();
        ds_pin = 1'b0;
        settle();
        moto_wr(8'h11, 1'b1);
        moto_rd(1'b1, on, dat, off);
        check("R4 oe without fresh strobe", {7'd0, on}, 8'h00);
        do_read(8'h7F, on, dat, off);
        check("R4 no write without fresh strobe", dat, 8'hFF);
        check("R4 fresh strobe restores read", {7'd0, on}, 8'h01);

        // R9: power fail blocks both directions, mode 0 as well
        pwr_fail = 1'b1;
        settle();
        addr_phase(8'h10);
        moto_wr(8'h22, 1'b1);
        do_read(8'h10, on, dat, off);
        check("R9 oe during power fail", {7'd0, on}, 8'h00);
        set_mode(1'b0);
        addr_phase(8'h20);
        intel_wr(8'h44, 1'b1);
        do_read(8'h20, on, dat, off);
        check("R9 oe during power fail mode 0", {7'd0, on}, 8'h00);
        pwr_fail = 1'b0;
        settle();
        do_read(8'h20, on, dat, off);
        check("R9 contents kept mode 0", dat, 8'h3C);
        set_mode(1'b1);
        do_read(8'h10, on, dat, off);
        check("R9 contents kept mode 1", dat, 8'hA5);

        // R10: write through the low alias, read through the high one
        addr_phase(8'h01);
        moto_wr(8'h77, 1'b1);
        do_read(8'h81, on, dat, off);
        check("R10 alias 0x81 reads 0x01", dat, 8'h77);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule